// File: doc/BRIEF.md
# Interrupt Delegation Arbiter

This block sits beside a processor's trap logic and decides, at every instruction boundary, whether one of the pending interrupts is to be taken now. A delegation register steers each interrupt either to the machine-level handler or to the supervisor-level handler. Each group is then judged against its own eligibility rule, which uses the current privilege level and the matching global enable bit. The lowest-numbered interrupt that passes wins, and its number goes out as a cause word that is XLEN bits wide.

The interrupt, enable and status inputs are plain levels, and the take strobe and cause are combinational outputs. There is no data stream, so the block has no valid/ready handshake. The trap sequencer holds `boundary_vld` high in cycles where an interrupt may be accepted. Software writes the delegation register through a one-cycle write strobe. Only bits in the delegable set (parameter `DELEG_MASK`, default bits 1, 5, 9 and 12) can be stored, and the value is visible on `dlg_q`.

Top module: `irq_deleg_arbiter`

## Requirements
- R1: After reset the delegation register `dlg_q` reads all zeros, and with no pending interrupt `take_irq` is 0.
- R2: A write stores `dlg_wr_data & DELEG_MASK`. Bits outside the mask (default mask 16'h1222) always read 0.
- R3: An interrupt that is not delegated (its `dlg_q` bit is 0) is eligible when the privilege is below machine, or when the privilege is machine (encoding 3) and `m_gie` is 1.
- R4: A delegated interrupt is eligible when the privilege is user (encoding 0), or when it is supervisor (encoding 1) and `s_gie` is 1. It is never eligible at machine privilege.
- R5: Privilege encoding 2 behaves exactly like user (encoding 0).
- R6: An interrupt is a candidate only when its `irq_pend` bit and its `irq_en` bit are both 1.
- R7: When several interrupts are eligible, the one with the lowest index is selected.
- R8: With at least one interrupt eligible, `irq_cause` has bit XLEN-1 set, carries the selected index in its low bits, and has every other bit 0. With none eligible, `irq_cause` is all zeros.
- R9: `take_irq` is 1 exactly when `boundary_vld` is 1 and some interrupt is eligible. `irq_cause` does not depend on `boundary_vld`.
- R10: A delegation write takes effect at the clock edge that samples it. Without a write, `dlg_q` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dlg_wr_en | input | 1 | Delegation register write strobe |
| dlg_wr_data | input | NUM_IRQ | Delegation write value |
| dlg_q | output | NUM_IRQ | Current delegation register |
| irq_pend | input | NUM_IRQ | Pending interrupt lines |
| irq_en | input | NUM_IRQ | Per-interrupt enables |
| cur_priv | input | 2 | Privilege: 0 user, 1 supervisor, 2 as user, 3 machine |
| m_gie | input | 1 | Machine global interrupt enable |
| s_gie | input | 1 | Supervisor global interrupt enable |
| boundary_vld | input | 1 | Instruction boundary where an interrupt may be taken |
| take_irq | output | 1 | Take the selected interrupt now |
| irq_cause | output | XLEN | Cause word of the selected interrupt |

## Verification
The bench sweeps every privilege encoding and both global enables against several delegation settings and many pending/enable patterns. It goes after the corner where supervisor privilege with `s_gie` clear must still take machine-handled interrupts: a design that gated everything on the supervisor enable would lose them. It also checks that machine privilege ignores delegated interrupts, that encoding 2 is treated as user rather than as machine, and that the lowest index wins. A design that scanned from the top would report the wrong cause. Masked-off delegation bits and write timing are checked through `dlg_q` and through the change in which interrupt gets taken right after the write.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPER = 2'd1,
    PRIV_RSVD  = 2'd2,
    PRIV_MACH  = 2'd3
  } priv_e;

  // Reserved encoding folds onto user level (R5)
  function automatic priv_e priv_fold(input logic [1:0] raw);
    priv_e p;
    case (raw)
      2'd1:    p = PRIV_SUPER;
      2'd3:    p = PRIV_MACH;
      default: p = PRIV_USER;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/irq_dlg_reg.sv
module irq_dlg_reg #(
  parameter int               NUM_IRQ    = 16,
  parameter logic [NUM_IRQ-1:0] DELEG_MASK = 16'h1222
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [NUM_IRQ-1:0] wr_data,
  output logic [NUM_IRQ-1:0] q
);

  // Only delegable positions get a flop; the rest are tied to zero (R2)
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
    if (DELEG_MASK[i]) begin : g_live
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     bit_q <= 1'b0;
        else if (wr_en) bit_q <= wr_data[i];
      end
      assign q[i] = bit_q;
    end else begin : g_tied
      assign q[i] = 1'b0;
    end
  end

endmodule

// File: rtl/irq_elig.sv
module irq_elig
  import irq_arb_pkg::*;
#(
  parameter int NUM_IRQ = 16
) (
  input  logic [NUM_IRQ-1:0] pend,
  input  logic [NUM_IRQ-1:0] en,
  input  logic [NUM_IRQ-1:0] dlg,
  input  logic [1:0]         priv_raw,
  input  logic               m_gie,
  input  logic               s_gie,
  output logic [NUM_IRQ-1:0] elig
);

  priv_e               priv;
  logic                mach_ok;
  logic                sup_ok;
  logic [NUM_IRQ-1:0]  cand;

  always_comb begin
    priv    = priv_fold(priv_raw);
    // machine handler: any lower level, or machine level with its enable
    mach_ok = (priv != PRIV_MACH) || m_gie;
    // supervisor handler: user level, or supervisor level with its enable
    sup_ok  = (priv == PRIV_USER) || ((priv == PRIV_SUPER) && s_gie);
    cand    = pend & en;
    elig    = (cand & ~dlg & {NUM_IRQ{mach_ok}})
            | (cand &  dlg & {NUM_IRQ{sup_ok}});
  end

endmodule

// File: rtl/irq_low_pick.sv
module irq_low_pick #(
  parameter int NUM_IRQ = 16,
  localparam int IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic [NUM_IRQ-1:0] req,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);

  logic [NUM_IRQ-1:0] seen_below;
  logic [NUM_IRQ-1:0] first;

  assign seen_below[0] = 1'b0;
  for (genvar i = 1; i < NUM_IRQ; i++) begin : g_chain
    assign seen_below[i] = seen_below[i-1] | req[i-1];
  end

  assign first = req & ~seen_below;
  assign any   = |req;

  always_comb begin
    idx = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (first[i]) idx = idx | IDX_W'(i);
    end
  end

endmodule

// File: rtl/irq_deleg_arbiter.sv
module irq_deleg_arbiter #(
  parameter int                 NUM_IRQ    = 16,
  parameter int                 XLEN       = 32,
  parameter logic [NUM_IRQ-1:0] DELEG_MASK = 16'h1222
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dlg_wr_en,
  input  logic [NUM_IRQ-1:0] dlg_wr_data,
  output logic [NUM_IRQ-1:0] dlg_q,
  input  logic [NUM_IRQ-1:0] irq_pend,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic [1:0]         cur_priv,
  input  logic               m_gie,
  input  logic               s_gie,
  input  logic               boundary_vld,
  output logic               take_irq,
  output logic [XLEN-1:0]    irq_cause
);

  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic [NUM_IRQ-1:0] elig;
  logic               any_elig;
  logic [IDX_W-1:0]   win_idx;

  irq_dlg_reg #(.NUM_IRQ(NUM_IRQ), .DELEG_MASK(DELEG_MASK)) u_dlg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (dlg_wr_en),
    .wr_data (dlg_wr_data),
    .q       (dlg_q)
  );

  irq_elig #(.NUM_IRQ(NUM_IRQ)) u_elig (
    .pend     (irq_pend),
    .en       (irq_en),
    .dlg      (dlg_q),
    .priv_raw (cur_priv),
    .m_gie    (m_gie),
    .s_gie    (s_gie),
    .elig     (elig)
  );

  irq_low_pick #(.NUM_IRQ(NUM_IRQ)) u_pick (
    .req (elig),
    .any (any_elig),
    .idx (win_idx)
  );

  always_comb begin
    irq_cause              = '0;
    irq_cause[XLEN-1]      = any_elig;
    irq_cause[IDX_W-1:0]   = any_elig ? win_idx : '0;
  end

  assign take_irq = boundary_vld & any_elig;

endmodule

// File: rtl/irq_deleg_arbiter_chk.sv
module irq_deleg_arbiter_chk #(
  parameter int                 NUM_IRQ    = 16,
  parameter int                 XLEN       = 32,
  parameter logic [NUM_IRQ-1:0] DELEG_MASK = 16'h1222
) (
  input logic               clk,
  input logic               rst_n,
  input logic               dlg_wr_en,
  input logic [NUM_IRQ-1:0] dlg_wr_data,
  input logic [NUM_IRQ-1:0] dlg_q,
  input logic [NUM_IRQ-1:0] irq_pend,
  input logic [NUM_IRQ-1:0] irq_en,
  input logic [1:0]         cur_priv,
  input logic               m_gie,
  input logic               s_gie,
  input logic               boundary_vld,
  input logic               take_irq,
  input logic [XLEN-1:0]    irq_cause
);

  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic [IDX_W-1:0] sel;
  assign sel = irq_cause[IDX_W-1:0];

  a_r9_take_needs_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> boundary_vld);

  a_r8_cause_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> irq_cause[XLEN-1]);

  a_r6_selected_is_live: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> (irq_pend[sel] && irq_en[sel]));

  a_r3_mach_level_rule: assert property (@(posedge clk) disable iff (!rst_n)
    (take_irq && cur_priv == 2'd3) |-> (m_gie && !dlg_q[sel]));

  a_r2_mask_respected: assert property (@(posedge clk) disable iff (!rst_n)
    (dlg_q & ~DELEG_MASK) == '0);

  a_r10_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    dlg_wr_en |=> (dlg_q == ($past(dlg_wr_data) & DELEG_MASK)));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dlg_wr_en |=> $stable(dlg_q));

endmodule

bind irq_deleg_arbiter irq_deleg_arbiter_chk #(
  .NUM_IRQ(NUM_IRQ), .XLEN(XLEN), .DELEG_MASK(DELEG_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dlg_wr_en(dlg_wr_en), .dlg_wr_data(dlg_wr_data),
  .dlg_q(dlg_q), .irq_pend(irq_pend), .irq_en(irq_en), .cur_priv(cur_priv),
  .m_gie(m_gie), .s_gie(s_gie), .boundary_vld(boundary_vld),
  .take_irq(take_irq), .irq_cause(irq_cause)
);

// File: tb/irq_deleg_arbiter_test.sv
module irq_deleg_arbiter_test;

  localparam int          CLK_PERIOD = 10;
  localparam int          N          = 16;
  localparam int          XL         = 32;
  localparam logic [N-1:0] MASK      = 16'h1222;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dlg_wr_en = 1'b0;
  logic [N-1:0]  dlg_wr_data = '0;
  logic [N-1:0]  dlg_q;
  logic [N-1:0]  irq_pend = '0;
  logic [N-1:0]  irq_en = '0;
  logic [1:0]    cur_priv = 2'd3;
  logic          m_gie = 1'b0;
  logic          s_gie = 1'b0;
  logic          boundary_vld = 1'b0;
  logic          take_irq;
  logic [XL-1:0] irq_cause;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_deleg_arbiter #(.NUM_IRQ(N), .XLEN(XL), .DELEG_MASK(MASK)) uut (
    .clk(clk), .rst_n(rst_n), .dlg_wr_en(dlg_wr_en), .dlg_wr_data(dlg_wr_data),
    .dlg_q(dlg_q), .irq_pend(irq_pend), .irq_en(irq_en), .cur_priv(cur_priv),
    .m_gie(m_gie), .s_gie(s_gie), .boundary_vld(boundary_vld),
    .take_irq(take_irq), .irq_cause(irq_cause)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_dlg(input logic [N-1:0] d);
    @(negedge clk);
    dlg_wr_en   = 1'b1;
    dlg_wr_data = d;
    @(negedge clk);
    dlg_wr_en   = 1'b0;
  endtask

  // Reference model written from the requirements
  function automatic logic [XL-1:0] model_cause(
      input logic [N-1:0] p, input logic [N-1:0] e, input logic [N-1:0] d,
      input logic [1:0] pr, input logic mg, input logic sg);
    logic [XL-1:0] c;
    logic mok, sok, hit;
    mok = (pr != 2'd3) || mg;
    sok = (pr == 2'd0) || (pr == 2'd2) || ((pr == 2'd1) && sg);
    c   = '0;
    hit = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!hit && p[i] && e[i] && (d[i] ? sok : mok)) begin
        hit = 1'b1;
        c   = (XL'(1) << (XL-1)) | XL'(i);
      end
    end
    return c;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] dsets [4];
    dsets[0] = 16'h0000; dsets[1] = 16'hFFFF; dsets[2] = 16'h0202; dsets[3] = 16'h1020;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 dlg_q in reset", 64'(dlg_q), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 dlg_q after reset", 64'(dlg_q), 64'h0);
    chk("R1 no take when idle", 64'(take_irq), 64'h0);

    // R2: write mask
    write_dlg(16'hFFFF);
    chk("R2 all ones masked", 64'(dlg_q), 64'(16'hFFFF & MASK));
    write_dlg(16'hEDDD);
    chk("R2 non-delegable bits dropped", 64'(dlg_q), 64'h0);

    // R10: timing of write and its effect on arbitration
    cur_priv = 2'd1; s_gie = 1'b0; m_gie = 1'b0; boundary_vld = 1'b1;
    irq_pend = 16'h0002; irq_en = 16'hFFFF;
    #1;
    chk("R3 undelegated taken at S with s_gie clear", 64'(take_irq), 64'h1);
    @(negedge clk);
    dlg_wr_en = 1'b1; dlg_wr_data = 16'h0002;
    #1;
    chk("R10 old value before edge", 64'(dlg_q), 64'h0);
    @(posedge clk); #1;
    dlg_wr_en = 1'b0;
    chk("R10 new value after edge", 64'(dlg_q), 64'h0002);
    chk("R4 delegated blocked at S with s_gie clear", 64'(take_irq), 64'h0);
    repeat (2) @(negedge clk);
    chk("R10 holds without write", 64'(dlg_q), 64'h0002);

    // R5, R6, R9 spot checks
    cur_priv = 2'd2; #1;
    chk("R5 encoding 2 acts as user", 64'(take_irq), 64'h1);
    irq_en = 16'hFFFD; #1;
    chk("R6 disabled line ignored", 64'(take_irq), 64'h0);
    chk("R8 cause zero when none", 64'(irq_cause), 64'h0);
    irq_en = 16'hFFFF; irq_pend = 16'h0822; boundary_vld = 1'b0; #1;
    chk("R9 no take without boundary", 64'(take_irq), 64'h0);
    chk("R9 cause still valid", 64'(irq_cause), 64'(32'h8000_0001));
    cur_priv = 2'd3; m_gie = 1'b1; boundary_vld = 1'b1; #1;
    chk("R7 lowest undelegated wins at M", 64'(irq_cause), 64'(32'h8000_0005));

    // Sweep
    for (int ds = 0; ds < 4; ds++) begin
      logic [N-1:0] dv;
      write_dlg(dsets[ds]);
      dv = dsets[ds] & MASK;
      chk("R2 sweep register", 64'(dlg_q), 64'(dv));
      for (int pr = 0; pr < 4; pr++)
        for (int gm = 0; gm < 2; gm++)
          for (int gs = 0; gs < 2; gs++)
            for (int k = 0; k < 64; k++) begin
              logic [XL-1:0] ec;
              cur_priv     = 2'(pr);
              m_gie        = gm[0];
              s_gie        = gs[0];
              irq_pend     = 16'((k * 16'h9E37) ^ (k << 5));
              irq_en       = k[0] ? 16'hFFFF : ~16'(k * 16'h3111);
              boundary_vld = (k % 5) != 0;
              #1;
              ec = model_cause(irq_pend, irq_en, dv, cur_priv, m_gie, s_gie);
              chk("R3/R4/R5/R7/R8 cause", 64'(irq_cause), 64'(ec));
              chk("R6/R9 take", 64'(take_irq), 64'(boundary_vld & ec[XL-1]));
            end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule